// File: doc/BRIEF.md
# Boot Strap Mode Controller

This block decides, once per reset, how the chip boots. Two strap pads (GPIO31 and GPIO30) pass through a two-flop synchroniser. Their value is latched on the first clock edge after the internally synchronised reset is released. The latched pair selects one of four boot modes. Three of them attach an external processor through one host interface: a parallel host port, a high-speed serial link, or SPI in slave mode. The fourth is standalone operation, where the on-chip processor loads its firmware from an I2C EEPROM.

A boot window timer runs after the capture. Its length is a cycle count derived from the clock frequency and a window length in microseconds. While the window runs, every pin stays a plain input and no interface is enabled. When the window expires, a done flag rises and the decoded mode takes effect:

- **Coprocessor modes.** Exactly one host interface enable goes high, and the strap pads return to ordinary GPIO use.
- **Standalone mode.** The five upper GPIO pins are reassigned: two to the EEPROM bus, two to a debug UART, and one to an OTG ID input. Port 1A then takes its USB role from the debounced ID pin, and the other ports stay peripherals.

Top module: `bootStrapCtl`

## Requirements
- R1: While reset is held, and until `bootDone` rises, `hostIfEn`, `pinOutEn`, `pinFunc` and `portIsHost` are all zero, and `bootDone` is 0.
- R2: `bootMode` equals the strap value {strapPin[1]=GPIO31, strapPin[0]=GPIO30} seen at the pads on the first clock edge after `rstN` rises. The value is latched on the third edge after release. The encoding is 00 parallel host port, 01 high-speed serial, 10 SPI slave, 11 standalone.
- R3: Once latched, `bootMode` ignores any later change on `strapPin` until the next reset.
- R4: `bootDone` is 0 after edge WINDOW_CYCLES+2 following `rstN` release and 1 after edge WINDOW_CYCLES+3. It then stays 1 until reset. WINDOW_CYCLES = CLK_FREQ_HZ/1000000*WINDOW_US.
- R5: In the coprocessor modes, once `bootDone` is 1, exactly the selected bit of `hostIfEn` is 1: bit0 for the parallel host port, bit1 for serial, bit2 for SPI. `pinFunc` is all GPIO (zero) and `pinOutEn` is 0, so the strap pads are released.
- R6: In standalone mode, once `bootDone` is 1, `hostIfEn` is 0. Field `pinFunc[2i+1:2i]` belongs to GPIO(27+i) and uses the codes 00 GPIO, 01 EEPROM, 10 UART, 11 OTG ID. The values are GPIO31 and GPIO30 = 01, GPIO29 = 11, and GPIO28 and GPIO27 = 10. `pinOutEn` (bit i is GPIO(27+i), 1 = output) is 5'b11010.
- R7: `portIsHost` bits 0 to 3 give ports 1A, 1B, 2A and 2B, with 1 meaning host. Bits 3:1 are always 0. Bit0 is the inverse of the debounced ID pin in standalone mode after `bootDone`, and 0 in every other case.
- R8: A change on `otgIdPin` held steady reaches the debounced ID after edge ID_DEBOUNCE+2 following the change. It has not reached it after edge ID_DEBOUNCE+1. A pulse shorter than ID_DEBOUNCE cycles is ignored.
- R9: Asserting `rstN` after a completed boot clears `bootDone` and all outputs, and the next release latches the new strap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| strapPin | input | 2 | Strap pads; bit1 is GPIO31, bit0 is GPIO30 |
| otgIdPin | input | 1 | OTG ID pad (GPIO29) |
| bootMode | output | 2 | Latched boot mode code |
| bootDone | output | 1 | Boot window expired |
| hostIfEn | output | 3 | One-hot host interface enable (parallel, serial, SPI) |
| pinFunc | output | 10 | Function code per pin, GPIO27 to GPIO31 |
| pinOutEn | output | 5 | Direction per pin, 1 = output |
| portIsHost | output | 4 | USB role per port, 1 = host |

## Verification
The hardest case to reach from the ports is the ID debounce in standalone mode. It can only be observed after a full boot window in mode 11, and only through the port 1A role bit. It also needs pulses of exactly one cycle less than the debounce count.

The bench boots into standalone mode with a short window. It then drives a directed edge-exact transition, followed by randomly sized sub-threshold pulses. The strap pads are randomised on every cycle after capture in every boot, so latch stability is exercised under stress.

// File: rtl/bootStrapPkg.sv
package bootStrapPkg;
  localparam int PIN_COUNT  = 5;
  localparam int IF_COUNT   = 3;
  localparam int PORT_COUNT = 4;
  localparam int FUNC_W     = 2;

  typedef enum logic [1:0] {
    MODE_PAR  = 2'b00,
    MODE_SER  = 2'b01,
    MODE_SPI  = 2'b10,
    MODE_SOLO = 2'b11
  } bootMode_e;

  typedef enum logic [FUNC_W-1:0] {
    FN_GPIO   = 2'b00,
    FN_EEPROM = 2'b01,
    FN_UART   = 2'b10,
    FN_OTGID  = 2'b11
  } pinFunc_e;

  typedef struct packed {
    logic capture;
    logic apply;
  } ctlStrobes_t;

  // Pin index i stands for GPIO(27+i)
  function automatic pinFunc_e soloFunc(input int idx);
    case (idx)
      4, 3:    return FN_EEPROM;
      2:       return FN_OTGID;
      default: return FN_UART;
    endcase
  endfunction

  function automatic logic soloDrive(input int idx);
    return (idx == 4) || (idx == 3) || (idx == 1);
  endfunction
endpackage

// File: rtl/bootStrapCtrl.sv
module bootStrapCtrl
  import bootStrapPkg::*;
#(
  parameter int WINDOW_CYCLES = 375000
) (
  input  logic        clk,
  input  logic        rstN,
  output logic        sysRstN,
  output ctlStrobes_t strobes,
  output logic        bootDone
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW_CYCLES - 1);

  typedef enum logic [1:0] {ST_CAPT, ST_WAIT, ST_DONE} state_e;

  logic [1:0]    rstSync;
  state_e        state;
  logic [CW-1:0] winCnt;

  // Reset asserts at once and releases on the second clock edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstSync <= '0;
    else       rstSync <= {rstSync[0], 1'b1};
  end
  assign sysRstN = rstSync[1];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      state  <= ST_CAPT;
      winCnt <= '0;
    end else begin
      case (state)
        ST_CAPT: begin
          state  <= ST_WAIT;
          winCnt <= '0;
        end
        ST_WAIT: begin
          if (winCnt == WIN_LAST) state <= ST_DONE;
          else                    winCnt <= winCnt + 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = sysRstN && (state == ST_CAPT);
    strobes.apply   = (state == ST_DONE);
  end
  assign bootDone = strobes.apply;

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    bootDone |=> bootDone);

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    winCnt <= WIN_LAST);

  // R2
  capture_once_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.capture |=> !strobes.capture);
endmodule

// File: rtl/bootStrapDp.sv
module bootStrapDp
  import bootStrapPkg::*;
#(
  parameter int ID_DEBOUNCE = 16
) (
  input  logic                      clk,
  input  logic                      sysRstN,
  input  ctlStrobes_t               strobes,
  input  logic [1:0]                strapPin,
  input  logic                      otgIdPin,
  output logic [1:0]                bootMode,
  output logic [IF_COUNT-1:0]       hostIfEn,
  output logic [PIN_COUNT*FUNC_W-1:0] pinFunc,
  output logic [PIN_COUNT-1:0]      pinOutEn,
  output logic [PORT_COUNT-1:0]     portIsHost
);
  localparam int DW = $clog2(ID_DEBOUNCE + 1);
  localparam logic [DW-1:0] DB_LAST = DW'(ID_DEBOUNCE - 1);

  logic [1:0]    strapS0, strapS1;
  logic [1:0]    idSync;
  bootMode_e     modeReg;
  logic          idStable;
  logic [DW-1:0] dbCnt;
  logic          solo;

  always_ff @(posedge clk) begin
    strapS0 <= strapPin;
    strapS1 <= strapS0;
    idSync  <= {idSync[0], otgIdPin};
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)             modeReg <= MODE_PAR;
    else if (strobes.capture) modeReg <= bootMode_e'(strapS1);
  end
  assign bootMode = modeReg;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      idStable <= 1'b1;
      dbCnt    <= '0;
    end else if (idSync[1] != idStable) begin
      if (dbCnt == DB_LAST) begin
        idStable <= idSync[1];
        dbCnt    <= '0;
      end else begin
        dbCnt <= dbCnt + 1'b1;
      end
    end else begin
      dbCnt <= '0;
    end
  end

  assign solo = strobes.apply && (modeReg == MODE_SOLO);

  for (genvar g = 0; g < IF_COUNT; g++) begin : gIf
    assign hostIfEn[g] = strobes.apply && (modeReg == bootMode_e'(g));
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : gPin
    assign pinFunc[p*FUNC_W +: FUNC_W] = solo ? soloFunc(p) : FN_GPIO;
    assign pinOutEn[p]                 = solo && soloDrive(p);
  end

  assign portIsHost = {{(PORT_COUNT-1){1'b0}}, solo && !idStable};

  // R1
  always @(posedge clk) begin
    if (!sysRstN) begin
      quiet_reset_chk: assert (hostIfEn == '0 && pinOutEn == '0 && portIsHost == '0)
        else $error("outputs active in reset");
    end
  end

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !strobes.capture |=> $stable(modeReg));

  // R5
  one_if_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $onehot0(hostIfEn));

  // R6
  solo_no_if_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (strobes.apply && modeReg == MODE_SOLO) |-> hostIfEn == '0);

  // R7
  other_ports_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    portIsHost[PORT_COUNT-1:1] == '0);

  // R8
  debounce_gate_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (idStable != $past(idStable)) |-> $past(dbCnt) == DB_LAST);
endmodule

// File: rtl/bootStrapCtl.sv
module bootStrapCtl
  import bootStrapPkg::*;
#(
  parameter int CLK_FREQ_HZ = 125000000,
  parameter int WINDOW_US   = 3000,
  parameter int ID_DEBOUNCE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  strapPin,
  input  logic        otgIdPin,
  output logic [1:0]  bootMode,
  output logic        bootDone,
  output logic [2:0]  hostIfEn,
  output logic [9:0]  pinFunc,
  output logic [4:0]  pinOutEn,
  output logic [3:0]  portIsHost
);
  localparam int WINDOW_CYCLES = CLK_FREQ_HZ / 1000000 * WINDOW_US;

  logic        sysRstN;
  ctlStrobes_t strobes;

  bootStrapCtrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sysRstN  (sysRstN),
    .strobes  (strobes),
    .bootDone (bootDone)
  );

  bootStrapDp #(.ID_DEBOUNCE(ID_DEBOUNCE)) uDp (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .strobes    (strobes),
    .strapPin   (strapPin),
    .otgIdPin   (otgIdPin),
    .bootMode   (bootMode),
    .hostIfEn   (hostIfEn),
    .pinFunc    (pinFunc),
    .pinOutEn   (pinOutEn),
    .portIsHost (portIsHost)
  );
endmodule

// File: tb/bootStrapCtl_test.sv
module bootStrapCtl_test;
  localparam int CLKHZ = 125000000;
  localparam int WUS   = 1;
  localparam int DEB   = 4;
  localparam int W     = CLKHZ / 1000000 * WUS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] strapPin = 2'b00;
  logic       otgIdPin = 1'b1;
  logic [1:0] bootMode;
  logic       bootDone;
  logic [2:0] hostIfEn;
  logic [9:0] pinFunc;
  logic [4:0] pinOutEn;
  logic [3:0] portIsHost;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bootStrapCtl #(.CLK_FREQ_HZ(CLKHZ), .WINDOW_US(WUS), .ID_DEBOUNCE(DEB)) uut (
    .clk(clk), .rstN(rstN), .strapPin(strapPin), .otgIdPin(otgIdPin),
    .bootMode(bootMode), .bootDone(bootDone), .hostIfEn(hostIfEn),
    .pinFunc(pinFunc), .pinOutEn(pinOutEn), .portIsHost(portIsHost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expIf(input logic [1:0] m);
    return (m == 2'b11) ? 3'b000 : (3'b001 << m);
  endfunction

  function automatic logic [9:0] expFunc(input logic [1:0] m);
    return (m == 2'b11) ? {2'b01, 2'b01, 2'b11, 2'b10, 2'b10} : 10'd0;
  endfunction

  function automatic logic [4:0] expOe(input logic [1:0] m);
    return (m == 2'b11) ? 5'b11010 : 5'b00000;
  endfunction

  function automatic logic [31:0] quietVec();
    return {13'd0, hostIfEn, pinOutEn, pinFunc, portIsHost, bootDone};
  endfunction

  task automatic runBoot(input logic [1:0] m, input bit afterBoot);
    @(negedge clk);
    rstN = 1'b0;
    strapPin = m;
    repeat (3) @(negedge clk);
    if (afterBoot) chk("R9 reset clears", quietVec(), 32'd0);
    else           chk("R1 reset quiet", quietVec(), 32'd0);
    rstN = 1'b1;
    for (int k = 1; k <= W + 3; k++) begin
      @(negedge clk);
      if (k == 3) chk("R2 latched mode", {30'd0, bootMode}, {30'd0, m});
      if (k >= 3) strapPin = 2'($urandom);
      if (k == W + 2) begin
        chk("R4 done low before window end", {31'd0, bootDone}, 32'd0);
        chk("R1 quiet in window", quietVec(), 32'd0);
      end
    end
    chk("R4 done high", {31'd0, bootDone}, 32'd1);
    chk("R3 mode kept", {30'd0, bootMode}, {30'd0, m});
    if (m == 2'b11) begin
      chk("R6 iface", {29'd0, hostIfEn}, 32'd0);
      chk("R6 func", {22'd0, pinFunc}, {22'd0, expFunc(m)});
      chk("R6 dir", {27'd0, pinOutEn}, {27'd0, expOe(m)});
    end else begin
      chk("R5 iface", {29'd0, hostIfEn}, {29'd0, expIf(m)});
      chk("R5 func", {22'd0, pinFunc}, 32'd0);
      chk("R5 dir", {27'd0, pinOutEn}, 32'd0);
    end
    chk("R7 roles", {28'd0, portIsHost}, {31'd0, (m == 2'b11) && !otgIdPin});
    repeat (5) begin
      @(negedge clk);
      strapPin = 2'($urandom);
    end
    chk("R3 mode kept late", {30'd0, bootMode}, {30'd0, m});
    chk("R4 done sticky", {31'd0, bootDone}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // Directed: each mode once
    runBoot(2'b00, 1'b0);
    runBoot(2'b01, 1'b1);
    runBoot(2'b10, 1'b1);
    runBoot(2'b11, 1'b1);

    // Abort mid-window, then boot with a different strap (R9)
    @(negedge clk);
    rstN = 1'b0;
    strapPin = 2'b01;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 aborted window not done", {31'd0, bootDone}, 32'd0);
    runBoot(2'b10, 1'b1);

    // Random modes
    for (int i = 0; i < 8; i++) runBoot(2'($urandom), 1'b1);

    // Coprocessor mode ignores ID (R7)
    otgIdPin = 1'b0;
    runBoot(2'b00, 1'b1);
    repeat (DEB + 4) @(negedge clk);
    chk("R7 coproc 1A peripheral", {28'd0, portIsHost}, 32'd0);
    otgIdPin = 1'b1;

    // Standalone ID debounce (R8)
    runBoot(2'b11, 1'b1);
    repeat (DEB + 4) @(negedge clk);
    chk("R7 solo id high peripheral", {28'd0, portIsHost}, 32'd0);
    otgIdPin = 1'b0;
    repeat (DEB + 1) @(negedge clk);
    chk("R8 not yet host", {31'd0, portIsHost[0]}, 32'd0);
    @(negedge clk);
    chk("R8 host after debounce", {31'd0, portIsHost[0]}, 32'd1);
    chk("R7 other ports peripheral", {29'd0, portIsHost[3:1]}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      int len;
      len = $urandom_range(1, DEB - 1);
      otgIdPin = 1'b1;
      repeat (len) @(negedge clk);
      otgIdPin = 1'b0;
      repeat (DEB + 4) @(negedge clk);
      chk("R8 short pulse ignored", {31'd0, portIsHost[0]}, 32'd1);
    end

    otgIdPin = 1'b1;
    repeat (DEB + 1) @(negedge clk);
    chk("R8 not yet peripheral", {31'd0, portIsHost[0]}, 32'd1);
    @(negedge clk);
    chk("R8 peripheral after debounce", {31'd0, portIsHost[0]}, 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule